// File: doc/BRIEF.md
# Dual-Fetch Multiply-Accumulate Engine

This block runs sum-of-products loops at one product per clock. Two operand registers, X and Y, feed a signed 16×16 multiplier. The product is sign-extended and added into a 40-bit accumulator. In the same cycle, the next X operand is read from a data-memory port and the next Y operand from a program-memory port. Registers are read at the start of a cycle and written at its end, so each product uses the operands that the previous cycle fetched.

Each memory port has its own address generator. A generator holds four index registers and four modify registers. The index register chosen for a run supplies the address, and after each access it is advanced by the chosen modify register, wrapping modulo 2^14. A run begins with a start pulse and a count N. The engine spends one priming cycle loading both operand registers, then performs N multiply-accumulate cycles and pulses done. In fetch-only mode the same fetch and address sequence happens but the accumulator is left alone. A 16-bit feedback register sits beside the accumulator. Only the configuration port writes it; a run never does.

Top module: `mac_dual_fetch`

## Requirements
- R1: After reset, acc_o, fb_o, dm_addr_o and pm_addr_o are zero, busy_o and done_o are low, and every index and modify register holds zero.
- R2: With the accumulator cleared, a run of count N leaves acc_o equal to the sum over j=0..N-1 of signed(X_j)·signed(Y_j). Each 32-bit product is sign-extended to 40 bits before it is added.
- R3: Accumulation wraps modulo 2^40 with no saturation.
- R4: A start_i sampled while idle starts a run. Exactly one priming cycle is followed by N accumulate cycles with no stalls. done_o is high for exactly one cycle, starting at the (N+1)-th rising edge after the edge that sampled start_i. busy_o is high from that edge until done_o rises.
- R5: X_j is always the data-memory word and Y_j the program-memory word read at fetch j. Fetch j happens in cycle j of the run, counting the priming cycle as 0. A product never uses a word fetched in its own cycle.
- R6: Fetch j reads address I+j·M, where I and M are the index and modify values selected for that memory. Selection uses dm_isel_i/dm_msel_i and pm_isel_i/pm_msel_i, latched at start, and any index may pair with any modify of the same generator. After a run the selected index holds I+(N+1)·M mod 2^14, shown on the address output while idle.
- R7: A configuration write (cfg_we_i) goes to cfg_kind_i 0 = index, 1 = modify or 2 = feedback register. It targets cfg_gen_i 0 = data generator or 1 = program generator, at slot cfg_sel_i, and uses the low 14 bits of cfg_data_i (all 16 bits for feedback). Writes while busy_o is high are ignored.
- R8: A run started with fetch_only_i high leaves acc_o unchanged while still advancing both addresses.
- R9: clear_i zeroes the accumulator at the next edge and takes priority over accumulation.
- R10: A run never changes fb_o.
- R11: start_i while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_gen_i | input | 1 | Target generator: 0 data, 1 program |
| cfg_kind_i | input | 2 | 0 index, 1 modify, 2 feedback register |
| cfg_sel_i | input | 2 | Register slot |
| cfg_data_i | input | 16 | Write data |
| dm_isel_i | input | 2 | Data-memory index select |
| dm_msel_i | input | 2 | Data-memory modify select |
| pm_isel_i | input | 2 | Program-memory index select |
| pm_msel_i | input | 2 | Program-memory modify select |
| start_i | input | 1 | Start a run |
| count_i | input | 16 | Number of accumulate cycles N |
| fetch_only_i | input | 1 | Run without accumulating |
| clear_i | input | 1 | Zero the accumulator |
| dm_addr_o | output | 14 | Data-memory read address |
| dm_re_o | output | 1 | Data-memory read enable |
| dm_rdata_i | input | 16 | Data-memory read data (same cycle) |
| pm_addr_o | output | 14 | Program-memory read address |
| pm_re_o | output | 1 | Program-memory read enable |
| pm_rdata_i | input | 16 | Program-memory read data (same cycle) |
| acc_o | output | 40 | Accumulator |
| fb_o | output | 16 | Feedback register |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest state to reach is a 40-bit accumulator wrap. Ordinary data would need over a thousand near-full-scale products before the sum wraps. The bench forces both memory models to return the most negative operand, sets the modify value to zero and runs 1100 cycles, so the wrapped total is known exactly. Address wrap and negative stepping are reached with an index near 2^14 and a modify of 2^14−1. Configuration writes and extra start pulses are issued in the middle of a run to show that both are ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PRIME = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CFG_INDEX    = 2'd0,
    CFG_MODIFY   = 2'd1,
    CFG_FEEDBACK = 2'd2
  } cfg_kind_e;
endpackage

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_mod_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [SW-1:0] isel_i,
  input  logic [SW-1:0] msel_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] mod_o
);
  logic [AW-1:0] idx_q [NREG];
  logic [AW-1:0] mod_q [NREG];

  assign addr_o = idx_q[isel_i];
  assign mod_o  = mod_q[msel_i];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[g] <= '0;
      end else if (step_i && isel_i == SW'(g)) begin
        idx_q[g] <= idx_q[g] + mod_q[msel_i];  // post-modify, wraps mod 2^AW
      end else if (wr_en_i && !wr_mod_i && wr_sel_i == SW'(g)) begin
        idx_q[g] <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mod_q[g] <= '0;
      end else if (wr_en_i && wr_mod_i && wr_sel_i == SW'(g)) begin
        mod_q[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  localparam int PW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  output logic [ACC_W-1:0] acc_o
);
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;
  logic [ACC_W-1:0]     acc_q;

  assign prod     = $signed(x_i) * $signed(y_i);
  assign prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (en_i)    acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import mac_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             accept_o,
  output logic             fetch_o,
  output logic             mac_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic             done_q;

  assign accept_o = start_i && state_q == SEQ_IDLE;
  assign fetch_o  = state_q != SEQ_IDLE;
  assign mac_o    = state_q == SEQ_RUN;
  assign busy_o   = state_q != SEQ_IDLE;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_PRIME;
          rem_q   <= count_i;
        end
        SEQ_PRIME: begin
          if (rem_q == '0) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_dual_fetch.sv
module mac_dual_fetch
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int AW    = 14,
  parameter int NREG  = 4,
  parameter int CNT_W = 16,
  localparam int SW   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_gen_i,
  input  logic [1:0]       cfg_kind_i,
  input  logic [SW-1:0]    cfg_sel_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic [SW-1:0]    dm_isel_i,
  input  logic [SW-1:0]    dm_msel_i,
  input  logic [SW-1:0]    pm_isel_i,
  input  logic [SW-1:0]    pm_msel_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             fetch_only_i,
  input  logic             clear_i,
  output logic [AW-1:0]    dm_addr_o,
  output logic             dm_re_o,
  input  logic [DW-1:0]    dm_rdata_i,
  output logic [AW-1:0]    pm_addr_o,
  output logic             pm_re_o,
  input  logic [DW-1:0]    pm_rdata_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [DW-1:0]    fb_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int NGEN = 2;

  logic          accept, fetch, mac, busy;
  logic          cfg_ok;
  logic [SW-1:0] isel_q [NGEN];
  logic [SW-1:0] msel_q [NGEN];
  logic [AW-1:0] addr_w [NGEN];
  logic [AW-1:0] mod_w  [NGEN];
  logic [SW-1:0] isel_in [NGEN];
  logic [SW-1:0] msel_in [NGEN];
  logic          fo_q;
  logic [DW-1:0] x_q, y_q, fb_q;
  logic [AW-1:0] dm_mod_w;

  assign cfg_ok     = cfg_we_i && !busy;
  assign isel_in[0] = dm_isel_i;
  assign msel_in[0] = dm_msel_i;
  assign isel_in[1] = pm_isel_i;
  assign msel_in[1] = pm_msel_i;

  loop_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (count_i),
    .accept_o (accept),
    .fetch_o  (fetch),
    .mac_o    (mac),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    logic gen_wr;
    assign gen_wr = cfg_ok && (cfg_gen_i == 1'(g)) &&
                    (cfg_kind_e'(cfg_kind_i) == CFG_INDEX ||
                     cfg_kind_e'(cfg_kind_i) == CFG_MODIFY);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        isel_q[g] <= '0;
        msel_q[g] <= '0;
      end else if (accept) begin
        isel_q[g] <= isel_in[g];
        msel_q[g] <= msel_in[g];
      end
    end

    addr_gen #(.AW(AW), .NREG(NREG)) u_ag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (gen_wr),
      .wr_mod_i  (cfg_kind_e'(cfg_kind_i) == CFG_MODIFY),
      .wr_sel_i  (cfg_sel_i),
      .wr_data_i (cfg_data_i[AW-1:0]),
      .isel_i    (isel_q[g]),
      .msel_i    (msel_q[g]),
      .step_i    (fetch),
      .addr_o    (addr_w[g]),
      .mod_o     (mod_w[g])
    );
  end

  // operands: X only from data memory, Y only from program memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      y_q  <= '0;
      fo_q <= 1'b0;
      fb_q <= '0;
    end else begin
      if (fetch) begin
        x_q <= dm_rdata_i;
        y_q <= pm_rdata_i;
      end
      if (accept) fo_q <= fetch_only_i;
      if (cfg_ok && cfg_kind_e'(cfg_kind_i) == CFG_FEEDBACK) fb_q <= cfg_data_i;
    end
  end

  mac_unit #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .en_i    (mac && !fo_q),
    .x_i     (x_q),
    .y_i     (y_q),
    .acc_o   (acc_o)
  );

  assign dm_mod_w  = mod_w[0];
  assign dm_addr_o = addr_w[0];
  assign pm_addr_o = addr_w[1];
  assign dm_re_o   = fetch;
  assign pm_re_o   = fetch;
  assign fb_o      = fb_q;
  assign busy_o    = busy;
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int AW    = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic             clear_i,
  input logic             fo_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [DW-1:0]    fb_i,
  input logic [AW-1:0]    dm_addr_i,
  input logic [AW-1:0]    dm_mod_i
);
  logic [AW-1:0] dm_next;
  assign dm_next = dm_addr_i + dm_mod_i;

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_i == '0);

  p_fetch_only_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && fo_i && !clear_i) |=> $stable(acc_i));

  p_fb_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(fb_i));

  p_post_modify_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> dm_addr_i == $past(dm_next));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clear_i) |=> $stable(acc_i));
endmodule

bind mac_dual_fetch mac_chk #(.DW(DW), .ACC_W(ACC_W), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .clear_i   (clear_i),
  .fo_i      (fo_q),
  .acc_i     (acc_o),
  .fb_i      (fb_o),
  .dm_addr_i (dm_addr_o),
  .dm_mod_i  (dm_mod_w)
);

// File: tb/sim_mac_dual_fetch.sv
module sim_mac_dual_fetch;
  typedef struct packed {
    logic [13:0] xi; logic [13:0] xm; logic [1:0] xis; logic [1:0] xms;
    logic [13:0] yi; logic [13:0] ym; logic [1:0] yis; logic [1:0] yms;
    logic [15:0] n;  logic fo; logic keep;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{14'd100,   14'd3,     2'd0, 2'd0, 14'd200,  14'd5,     2'd0, 2'd0, 16'd8,  1'b0, 1'b0},
    '{14'd16380, 14'd7,     2'd1, 2'd2, 14'd5,    14'd16383, 2'd3, 2'd1, 16'd20, 1'b0, 1'b0},
    '{14'd50,    14'd1,     2'd2, 2'd3, 14'd9000, 14'd2,     2'd2, 2'd0, 16'd1,  1'b0, 1'b1},
    '{14'd77,    14'd4,     2'd3, 2'd1, 14'd300,  14'd0,     2'd1, 2'd3, 16'd12, 1'b1, 1'b1},
    '{14'd0,     14'd0,     2'd0, 2'd0, 14'd0,    14'd0,     2'd0, 2'd0, 16'd0,  1'b0, 1'b0},
    '{14'd1234,  14'd11,    2'd2, 2'd2, 14'd4321, 14'd13,    2'd3, 2'd3, 16'd64, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_gen = 1'b0;
  logic [1:0]  cfg_kind = '0, cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic [1:0]  dm_isel = '0, dm_msel = '0, pm_isel = '0, pm_msel = '0;
  logic        start = 1'b0, fetch_only = 1'b0, clear = 1'b0;
  logic [15:0] count = '0;
  logic [13:0] dm_addr, pm_addr;
  logic        dm_re, pm_re, busy, done;
  logic [15:0] dm_rdata, pm_rdata, fb;
  logic [39:0] acc;
  logic        force_min = 1'b0;

  int checks = 0;
  int errors = 0;
  int edges;
  logic [39:0] exp_acc;

  always #4 clk = ~clk;

  function automatic logic [15:0] dm_f(input logic [13:0] a);
    return 16'((32'(a) * 32'd7919 + 32'h1234));
  endfunction
  function automatic logic [15:0] pm_f(input logic [13:0] a);
    return 16'((32'(a) * 32'd40503) ^ 32'h0000A5C3);
  endfunction

  assign dm_rdata = force_min ? 16'h8000 : dm_f(dm_addr);
  assign pm_rdata = force_min ? 16'h8000 : pm_f(pm_addr);

  mac_dual_fetch u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_gen_i(cfg_gen), .cfg_kind_i(cfg_kind),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .dm_isel_i(dm_isel), .dm_msel_i(dm_msel), .pm_isel_i(pm_isel), .pm_msel_i(pm_msel),
    .start_i(start), .count_i(count), .fetch_only_i(fetch_only), .clear_i(clear),
    .dm_addr_o(dm_addr), .dm_re_o(dm_re), .dm_rdata_i(dm_rdata),
    .pm_addr_o(pm_addr), .pm_re_o(pm_re), .pm_rdata_i(pm_rdata),
    .acc_o(acc), .fb_o(fb), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] sum_model(input logic [39:0] base, input vec_t v);
    longint s = longint'(base);
    for (int j = 0; j < int'(v.n); j++) begin
      logic [13:0] xa, ya;
      xa = 14'(v.xi + 14'(j) * v.xm);
      ya = 14'(v.yi + 14'(j) * v.ym);
      s += longint'($signed(dm_f(xa))) * longint'($signed(pm_f(ya)));
    end
    return 40'(s);
  endfunction

  task automatic cfg(input logic gen, input logic [1:0] kind, input logic [1:0] sel,
                     input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_gen = gen; cfg_kind = kind; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  // start a run and count edges until done; edges == N+1 expected
  task automatic run(input logic [15:0] n, input logic fo);
    @(negedge clk);
    start = 1'b1; count = n; fetch_only = fo;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 5000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 acc", 64'(acc), 64'd0);
    chk("R1 busy/done", {62'd0, busy, done}, 64'd0);
    chk("R1 fb", 64'(fb), 64'd0);
    chk("R1 addr", {36'd0, dm_addr, pm_addr}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 feedback register write
    cfg(1'b0, 2'd2, 2'd0, 16'hBEEF);
    chk("R7 fb write", 64'(fb), 64'hBEEF);

    exp_acc = '0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [13:0] xe, ye;
      v = VECS[i];
      cfg(1'b0, 2'd0, v.xis, 16'(v.xi));
      cfg(1'b0, 2'd1, v.xms, 16'(v.xm));
      cfg(1'b1, 2'd0, v.yis, 16'(v.yi));
      cfg(1'b1, 2'd1, v.yms, 16'(v.ym));
      dm_isel = v.xis; dm_msel = v.xms; pm_isel = v.yis; pm_msel = v.yms;
      if (!v.keep) begin
        do_clear();
        exp_acc = '0;
      end
      run(v.n, v.fo);
      if (!v.fo) exp_acc = sum_model(exp_acc, v);   // R2, R5; fetch-only keeps acc (R8)
      chk($sformatf("R4 done timing vec%0d", i), 64'(edges), 64'(int'(v.n) + 1));
      chk($sformatf("R2/R5/R8 acc vec%0d", i), 64'(acc), 64'(exp_acc));
      @(negedge clk);
      xe = 14'(v.xi + 14'(int'(v.n) + 1) * v.xm);
      ye = 14'(v.yi + 14'(int'(v.n) + 1) * v.ym);
      chk($sformatf("R6 dm addr vec%0d", i), 64'(dm_addr), 64'(xe));
      chk($sformatf("R6 pm addr vec%0d", i), 64'(pm_addr), 64'(ye));
      chk($sformatf("R10 fb vec%0d", i), 64'(fb), 64'hBEEF);
    end

    // R9 clear in idle
    do_clear();
    chk("R9 clear idle", 64'(acc), 64'd0);

    // R11 + R7: start and config write during a run are ignored
    begin
      vec_t v;
      v = '{14'd10, 14'd2, 2'd0, 2'd0, 14'd20, 14'd3, 2'd0, 2'd0, 16'd10, 1'b0, 1'b0};
      cfg(1'b0, 2'd0, 2'd0, 16'd10); cfg(1'b0, 2'd1, 2'd0, 16'd2);
      cfg(1'b1, 2'd0, 2'd0, 16'd20); cfg(1'b1, 2'd1, 2'd0, 16'd3);
      dm_isel = '0; dm_msel = '0; pm_isel = '0; pm_msel = '0;
      @(negedge clk); start = 1'b1; count = 16'd10; fetch_only = 1'b0;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      start = 1'b1; count = 16'd3;
      cfg_we = 1'b1; cfg_gen = 1'b0; cfg_kind = 2'd0; cfg_sel = 2'd0; cfg_data = 16'd999;
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      cfg_we = 1'b1; cfg_kind = 2'd2; cfg_data = 16'h1111;
      @(negedge clk);
      cfg_we = 1'b0;
      edges = 3;
      while (!done && edges < 5000) begin
        @(negedge clk);
        edges++;
      end
      chk("R11 done timing", 64'(edges), 64'd11);
      chk("R11 acc", 64'(acc), 64'(sum_model(40'd0, v)));
      @(negedge clk);
      chk("R7 write ignored while busy", 64'(dm_addr), 64'(14'(10 + 11 * 2)));
      chk("R7 fb write ignored while busy", 64'(fb), 64'hBEEF);
      @(negedge clk);
      chk("R11 no second run", {63'd0, busy}, 64'd0);
    end

    // R9 clear held through a run has priority
    @(negedge clk); clear = 1'b1;
    run(16'd5, 1'b0);
    chk("R9 clear priority", 64'(acc), 64'd0);
    @(negedge clk); clear = 1'b0;

    // R3 wrap: 1100 products of 2^30
    force_min = 1'b1;
    cfg(1'b0, 2'd1, 2'd0, 16'd0);
    cfg(1'b1, 2'd1, 2'd0, 16'd0);
    do_clear();
    run(16'd1100, 1'b0);
    chk("R3 wrap", 64'(acc), 64'(40'(longint'(76) <<< 30)));
    chk("R4 long run timing", 64'(edges), 64'd1101);
    force_min = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule